// File: doc/BRIEF.md
# Four-Switch Buck-Boost Gate Sequencer

This block drives the four MOSFET gates of a bidirectional, non-inverting buck-boost power stage. The stage has a high-side and a low-side switch on the buck leg, plus a boost switch and a charge switch on the other leg. Two mode inputs select one of three operating modes:

- step-down, with the battery feeding the bus;
- step-up, with the battery feeding a higher bus;
- charge, with the bus feeding the battery.

A free-running period counter produces a single pulse-width-modulated phase. The duty of that phase comes from a command word. The block steers the phase onto the gates through a per-mode table, so that in each mode one switch pair alternates and the remaining switches are held on or off.

Each gate has an on-delay, so a switch never turns on until its partner has been off for a programmed dead time. Two current-limit flags, one for each current direction, blank the alternating pair. Blanking starts on the cycle after either flag is seen and lasts until the next period begins. An illegal mode code shuts every gate and latches a fault that only reset clears.

Duty commands and mode changes are taken only at a period boundary, so a pulse is never cut or stretched within a period. When the mode changes, all gates start the new period off for one dead time.

Top module: `bbgate_seq`

## Requirements
- R1: Mode inputs {mode_up, mode_chg} = 00 select step-down. In step-down, g_hs is on in the active phase, g_ls in the complementary phase, g_bst is off and g_chg is held on.
- R2: Code 10 selects step-up. In step-up, g_hs is held on, g_ls is off, g_bst is on in the active phase and g_chg in the complementary phase.
- R3: Code 01 selects charge. In charge, g_hs is held on, g_ls is off, g_chg is on in the active phase and g_bst in the complementary phase.
- R4: The pairs (g_hs, g_ls) and (g_bst, g_chg) are never on together. A gate turns on only after its wanted state has held for DEAD_CYC consecutive cycles.
- R5: A period is PERIOD_CYC clock cycles. The active phase covers the first D cycles of the period, where D is the latched duty. D = 0 keeps the active switch off and the complementary switch on. D >= PERIOD_CYC keeps the active switch on continuously.
- R6: For 0 < D < PERIOD_CYC, the active switch conducts for D − DEAD_CYC cycles. A duty of DEAD_CYC or less produces no pulse at all.
- R7: duty_cmd is captured only on the last cycle of a period. A change during a period has no effect until the next period.
- R8: The mode inputs are captured only on the last cycle of a period. When the captured mode differs from the current one, all four gates are off for the first DEAD_CYC cycles of the new period.
- R9: oc_fwd or oc_rev high in a cycle turns both alternating switches of the current mode off from the next cycle. The held switch is not affected.
- R10: The blanking from R9 persists to the end of the period even if the flags drop. Switching resumes at the next period start, with each switched gate waiting DEAD_CYC cycles.
- R11: Mode code 11 in any cycle sets fault on the next cycle and forces all gates off. fault stays set until reset, even after a legal code returns.
- R12: During and after reset, all gates are off and fault is low. The block starts in step-down with duty 0, and its held gates turn on DEAD_CYC cycles after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| duty_cmd | input | $clog2(PERIOD_CYC+1) | Active-phase length in cycles, captured at period end |
| mode_up | input | 1 | Mode bit: step-up request |
| mode_chg | input | 1 | Mode bit: charge request |
| oc_fwd | input | 1 | Forward overcurrent flag |
| oc_rev | input | 1 | Reverse overcurrent flag |
| g_hs | output | 1 | Buck high-side gate |
| g_ls | output | 1 | Buck low-side gate |
| g_bst | output | 1 | Boost switch gate |
| g_chg | output | 1 | Charge switch gate |
| fault | output | 1 | Sticky illegal-mode fault |

## Verification
Continuous-duty periods that directly follow other continuous-duty periods are checked for gap-free conduction. A design that reapplied dead time at every boundary would show a notch there. Duties at or below the dead time are checked for a complete absence of pulses, which catches an on-delay that stretches or lets through runt pulses. Overcurrent is pulsed for two cycles in mid-period and the gates must stay off to the period end. A design that resumed on flag release, or blanked the held switch as well, would conduct early or drop the held gate. The duty command is rewritten at every period start and each mode change is checked for its one dead-time blackout. The illegal code is applied briefly to confirm that the fault survives a return to a legal code.

// File: rtl/bbgate_seq.sv
module bbgate_seq #(
  parameter int PERIOD_CYC = 1000,
  parameter int DEAD_CYC   = 10,
  localparam int CW = $clog2(PERIOD_CYC + 1),
  localparam int DW = $clog2(DEAD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] duty_cmd,
  input  logic          mode_up,
  input  logic          mode_chg,
  input  logic          oc_fwd,
  input  logic          oc_rev,
  output logic          g_hs,
  output logic          g_ls,
  output logic          g_bst,
  output logic          g_chg,
  output logic          fault
);

  localparam logic [1:0]    M_DN = 2'b00;
  localparam logic [1:0]    M_UP = 2'b10;
  localparam logic [1:0]    M_CH = 2'b01;
  localparam logic [CW-1:0] LAST = CW'(PERIOD_CYC - 1);
  localparam logic [DW-1:0] DLIM = DW'(DEAD_CYC);

  logic [CW-1:0] cnt;
  logic [CW-1:0] duty_q;
  logic [1:0]    mode_q;
  logic          oc_blk;
  logic [3:0]    want;
  logic [3:0]    gate;

  wire [1:0] mode_in = {mode_up, mode_chg};
  wire       edge_p  = (cnt == LAST);
  wire       legal   = (mode_in != 2'b11);
  wire       mswap   = edge_p && legal && (mode_in != mode_q);
  wire       act     = (cnt < duty_q);
  wire       sw_en   = !oc_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      duty_q <= '0;
      mode_q <= M_DN;
      oc_blk <= 1'b0;
      fault  <= 1'b0;
    end else begin
      cnt <= edge_p ? '0 : cnt + 1'b1;
      if (edge_p) duty_q <= duty_cmd;
      if (mswap) mode_q <= mode_in;
      if (oc_fwd || oc_rev) oc_blk <= 1'b1;
      else if (edge_p)      oc_blk <= 1'b0;
      if (!legal) fault <= 1'b1;
    end
  end

  always_comb begin
    case (mode_q)
      M_UP:    want = {1'b1, 1'b0, act && sw_en, !act && sw_en};
      M_CH:    want = {1'b1, 1'b0, !act && sw_en, act && sw_en};
      default: want = {act && sw_en, !act && sw_en, 1'b0, 1'b1};
    endcase
    if (fault) want = 4'b0000;
  end

  for (genvar i = 0; i < 4; i++) begin : g_ch
    logic [DW-1:0] age;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  age <= '0;
      else if (mswap || !want[i])  age <= '0;
      else if (age != DLIM)        age <= age + 1'b1;
    end
    assign gate[i] = want[i] && (age == DLIM);
  end

  assign {g_hs, g_ls, g_bst, g_chg} = gate;

  // R4
  buck_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) !(g_hs && g_ls));
  // R4
  bst_pair_chk: assert property (@(posedge clk) disable iff (!rst_n) !(g_bst && g_chg));
  // R4
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(g_hs) |-> !$past(g_ls));
  // R4
  chg_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(g_chg) |-> !$past(g_bst));
  // R5
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= LAST);
  // R7
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !edge_p |=> $stable(duty_q));
  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !edge_p |=> $stable(mode_q));
  // R9
  oc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oc_fwd || oc_rev) |=> ((mode_q == M_DN) ? (!g_hs && !g_ls) : (!g_bst && !g_chg)));
  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) fault |=> fault);
  // R11
  fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(g_hs || g_ls || g_bst || g_chg));

endmodule

// File: tb/bbgate_seq_tb_top.sv
module bbgate_seq_tb_top;
  localparam int P = 20;
  localparam int D = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [4:0] duty_cmd = '0;
  logic mode_up = 1'b0, mode_chg = 1'b0, oc_fwd = 1'b0, oc_rev = 1'b0;
  logic g_hs, g_ls, g_bst, g_chg, fault;

  bbgate_seq #(.PERIOD_CYC(P), .DEAD_CYC(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .duty_cmd(duty_cmd),
    .mode_up(mode_up), .mode_chg(mode_chg), .oc_fwd(oc_fwd), .oc_rev(oc_rev),
    .g_hs(g_hs), .g_ls(g_ls), .g_bst(g_bst), .g_chg(g_chg), .fault(fault));

  always #5 clk = ~clk;

  int cyc;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  int q_cyc[$];
  logic [4:0] q_val[$];
  string q_tag[$];
  int n_chk = 0, n_err = 0;
  bit done = 0;

  int cur_m = 0, cur_d = 0;
  bit cur_fresh = 1, cur_res = 0;

  function automatic logic [3:0] exp_g(int m, int d, int o, bit fr, bit rs, int blk);
    bit a, c, h;
    a = (d >= P) ? 1'b1 : (d > 0 && o >= D && o < d);
    c = (d >= P) ? 1'b0 : ((d == 0) ? 1'b1 : (o >= d + D));
    h = 1'b1;
    if (fr || rs) begin a = a && (o >= D); c = c && (o >= D); end
    if (fr) h = (o >= D);
    if (o > blk) begin a = 1'b0; c = 1'b0; end
    case (m)
      1:       return {h, 1'b0, a, c};
      2:       return {h, 1'b0, c, a};
      default: return {a, c, 1'b0, h};
    endcase
  endfunction

  task automatic push_period(int st, int m, int d, bit fr, bit rs, int blk, string tag);
    for (int o = 0; o < P; o++) begin
      q_cyc.push_back(st + o);
      q_val.push_back({exp_g(m, d, o, fr, rs, blk), 1'b0});
      q_tag.push_back(tag);
    end
  endtask

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic chk_now(logic [4:0] exp, string tag);
    n_chk++;
    if ({g_hs, g_ls, g_bst, g_chg, fault} !== exp) begin
      n_err++;
      $display("FAIL %s got=%b exp=%b", tag, {g_hs, g_ls, g_bst, g_chg, fault}, exp);
    end
  endtask

  task automatic step(int nm, int nd, bit chk, int blk, int which, string tag);
    int st;
    st = cyc;
    if (chk) push_period(st, cur_m, cur_d, cur_fresh, cur_res, blk, tag);
    mode_up  = (nm == 1);
    mode_chg = (nm == 2);
    duty_cmd = 5'(nd);
    if (blk < P) begin
      wait_to(st + blk);
      if (which == 1) oc_fwd = 1'b1; else oc_rev = 1'b1;
      wait_to(st + blk + 2);
      oc_fwd = 1'b0;
      oc_rev = 1'b0;
    end
    wait_to(st + P);
    cur_fresh = (nm != cur_m);
    cur_res   = (blk < P);
    cur_m = nm;
    cur_d = nd;
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        while (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
          n_chk++; n_err++;
          $display("FAIL %s cyc=%0d got=missed exp=%b", q_tag[0], q_cyc[0], q_val[0]);
          void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
        end
        while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
          n_chk++;
          if ({g_hs, g_ls, g_bst, g_chg, fault} !== q_val[0]) begin
            n_err++;
            $display("FAIL %s cyc=%0d got=%b exp=%b", q_tag[0], cyc,
                     {g_hs, g_ls, g_bst, g_chg, fault}, q_val[0]);
          end
          void'(q_cyc.pop_front()); void'(q_val.pop_front()); void'(q_tag.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog got=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_now(5'b00000, "R12 in reset");
    rst_n = 1'b1;
    step(0, 8,  1, P,  0, "R12 R5 R1 start");
    step(0, 2,  1, P,  0, "R1 R4 duty8");
    step(0, 0,  1, P,  0, "R6 R7 short duty");
    step(0, 20, 1, P,  0, "R1 R5 duty0");
    step(0, 20, 0, P,  0, "");
    step(0, 8,  1, P,  0, "R5 full duty");
    step(0, 8,  0, P,  0, "");
    step(0, 8,  1, 12, 1, "R9 R10 fwd blank");
    step(1, 10, 1, P,  0, "R10 resume down");
    step(1, 10, 1, P,  0, "R2 R8 to step-up");
    step(1, 10, 1, 5,  2, "R2 R9 rev blank");
    step(2, 9,  1, P,  0, "R10 resume up");
    step(2, 9,  1, P,  0, "R3 R8 to charge");
    step(2, 9,  1, P,  0, "R3 R4 charge");
    mode_up = 1'b1;
    for (int k = 1; k <= 25; k++) begin
      q_cyc.push_back(14 * P + k);
      q_val.push_back(5'b00001);
      q_tag.push_back("R11 fault");
    end
    wait_to(14 * P + 3);
    mode_up = 1'b0;
    wait_to(14 * P + 26);
    rst_n = 1'b0;
    mode_chg = 1'b0;
    duty_cmd = '0;
    repeat (2) @(negedge clk);
    chk_now(5'b00000, "R11 R12 fault cleared");
    rst_n = 1'b1;
    push_period(0, 0, 0, 1'b1, 1'b0, P, "R12 R11 after reset");
    wait_to(P);
    @(negedge clk);
    #2;
    if (q_cyc.size() != 0) begin
      n_chk++; n_err++;
      $display("FAIL scoreboard got=%0d exp=0 pending", q_cyc.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule